// File: doc/BRIEF.md
# Table-Write External Bus Sequencer

This block lets a small processor core store 16-bit words into memory that sits on a multiplexed 16-bit address/data bus. It keeps a 16-bit table pointer and a 16-bit table latch. The core issues one-byte commands at instruction boundaries. Two commands set the pointer bytes. A latch-only command fills the high half of the latch and leaves the bus idle. A write command fills the low half of the latch and starts a fixed bus transfer that lasts two machine cycles.

Every machine cycle has four phases, Q1 to Q4, and each phase is one clock. The first machine cycle of a write leaves the bus alone. In the second machine cycle the block does four things in order:
- It puts the pointer on the bus with the address strobe high during Q1.
- It drives the latch contents from Q2 to Q4.
- It pulses the write strobe low in Q3.
- It holds the read strobe high throughout.

The write command can ask for the pointer to advance by one once the transfer is over.

While a write is running, the block watches an interrupt request line. If interrupts are globally masked and the source is enabled, the block still finishes the transfer. It then pulses an acknowledge that clears the pending flag.

Top module: `tblwr_bus_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the following hold: the pointer and latch are 0, `busy`, `ale`, `ad_oe` and `int_ack` are 0, `wr_n` and `oe_n` are 1, `ad_out` is 0 and `q_phase` is 0.
- R2: `q_phase` counts 0,1,2,3,0,... on each clock after reset, with 0 meaning Q1 and 3 meaning Q4.
- R3: A command is taken only on a clock where `cmd_valid` is high, `q_phase` is 3 and `busy` is low. `cmd_op` is decoded as follows: 0 loads the pointer low byte, 1 loads the pointer high byte, 2 loads the latch high byte, and 3 loads the latch low byte and starts a write. A command presented in any other phase has no effect.
- R4: Loading a pointer byte or the latch high byte causes no bus activity. `busy` and `ad_oe` stay low.
- R5: A taken write raises `busy` for exactly 8 clocks, starting at the next clock. `ad_oe` is high only in the last 4 of those clocks, which form the second machine cycle.
- R6: `ale` is high only in Q1 of the second machine cycle, and `ad_out` then equals the pointer.
- R7: In Q2 to Q4 of the second machine cycle, `ad_out` equals {latch high byte, latch low byte}. `wr_n` is low only in Q3 of that cycle.
- R8: `oe_n` is high at all times.
- R9: When the write command has `cmd_inc` set to 1, the pointer becomes pointer+1 mod 2^16 on the clock after the write's last phase. When `cmd_inc` is 0, the pointer is unchanged. The write itself always uses the pointer value held before the increment.
- R10: A command that arrives while `busy` is high is ignored: the pointer and latch keep their values.
- R11: `int_ack` pulses for one clock, in Q4 of the second machine cycle, when all of these hold:
  - `int_glob_off` is 1;
  - `int_src_en` is 1;
  - `int_req` was high in the acceptance clock, in any clock of the write, or in that Q4 clock.

  Otherwise `int_ack` stays 0. The write length does not change in either case.
- R12: `ad_out` is 0 whenever `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one clock per Q phase |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (0 pointer low, 1 pointer high, 2 latch high, 3 latch low and write) |
| cmd_inc | input | 1 | Advance the pointer after this write |
| cmd_byte | input | 8 | Command data byte |
| int_req | input | 1 | Interrupt request from the source |
| int_glob_off | input | 1 | Global interrupt mask is set |
| int_src_en | input | 1 | Source enable bit |
| q_phase | output | 2 | Current phase, 0 = Q1 to 3 = Q4 |
| busy | output | 1 | Write sequence in progress |
| ale | output | 1 | Address latch strobe, active high |
| oe_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_oe | output | 1 | Bus drive enable; bus is tri-stated when low |
| ad_out | output | 16 | Value driven on the multiplexed bus |
| tbl_ptr | output | 16 | Current table pointer |
| int_ack | output | 1 | One-clock interrupt acknowledge |

## Verification
Two events can fall in the same clock: the interrupt acknowledge and the end of the write, where the pointer increments. A new command can also arrive in the Q4 that ends a write. The bench provokes both collisions:
- It raises `int_req` only in the final Q4 of a write.
- It presents commands at every Q4 of a write, including the last one.
- It runs a long stretch of random commands and interrupt inputs.

A behavioural model built on a countdown of remaining busy clocks sets the expected value of every output on every clock. The checks confirm three things: the acknowledge and the increment land together, the late request still counts, and the colliding command is dropped.

// File: rtl/tblwr_pkg.sv
package tblwr_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = WORD_W / 2;
    localparam int NUM_PH   = 4;
    localparam int PH_W     = $clog2(NUM_PH);

    typedef enum logic [1:0] {
        OP_PTR_LO = 2'd0,
        OP_PTR_HI = 2'd1,
        OP_LAT_HI = 2'd2,
        OP_WRITE  = 2'd3
    } tw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_XFER = 2'd2
    } tw_state_e;

    typedef struct packed {
        logic ale;
        logic oe_n;
        logic wr_n;
        logic drive;
    } tw_strobe_s;

    localparam tw_strobe_s STROBE_IDLE = '{ale: 1'b0, oe_n: 1'b1, wr_n: 1'b1, drive: 1'b0};

    function automatic logic [PH_W-1:0] strobe_phase_wr();
        return PH_W'(NUM_PH - 2);
    endfunction

endpackage

// File: rtl/tblwr_phase.sv
module tblwr_phase #(
    parameter int NPH = 4,
    parameter int PW  = $clog2(NPH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] ph,
    output logic          ph_last
);

    assign ph_last = (ph == PW'(NPH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (ph_last) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        !ph_last |=> (ph == PW'($past(ph) + 1)));

    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        ph_last |=> (ph == '0));

endmodule

// File: rtl/tblwr_regs.sv
module tblwr_regs #(
    parameter int W  = 16,
    parameter int BW = W / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_ptr_lo,
    input  logic          ld_ptr_hi,
    input  logic          ld_lat_hi,
    input  logic          ld_lat_lo,
    input  logic          bump,
    input  logic [BW-1:0] din,
    output logic [W-1:0]  ptr,
    output logic [W-1:0]  latch
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            latch <= '0;
        end else begin
            if (ld_ptr_lo) ptr[BW-1:0]   <= din;
            if (ld_ptr_hi) ptr[W-1:BW]   <= din;
            if (ld_lat_hi) latch[W-1:BW] <= din;
            if (ld_lat_lo) latch[BW-1:0] <= din;
            if (bump)      ptr           <= ptr + 1'b1;
        end
    end

    p_one_source_r3: assert property (@(posedge clk) disable iff (rst)
        $countones({ld_ptr_lo, ld_ptr_hi, ld_lat_hi, ld_lat_lo, bump}) <= 1);

endmodule

// File: rtl/tblwr_ctrl.sv
module tblwr_ctrl
    import tblwr_pkg::*;
#(
    parameter int W  = 16,
    parameter int BW = W / 2,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] ph,
    input  logic          ph_last,
    input  logic          cmd_valid,
    input  tw_op_e        cmd_op,
    input  logic          cmd_inc,
    input  logic          int_req,
    input  logic          int_glob_off,
    input  logic          int_src_en,
    input  logic [W-1:0]  ptr,
    input  logic [W-1:0]  latch,
    output logic          ld_ptr_lo,
    output logic          ld_ptr_hi,
    output logic          ld_lat_hi,
    output logic          ld_lat_lo,
    output logic          bump,
    output logic          busy,
    output tw_strobe_s    strobe,
    output logic [W-1:0]  ad_out,
    output logic          int_ack
);

    tw_state_e state;
    logic      inc_q;
    logic      seen_q;
    logic      accept;
    logic      in_xfer;

    assign accept  = cmd_valid && ph_last && (state == ST_IDLE);
    assign in_xfer = (state == ST_XFER);
    assign busy    = (state != ST_IDLE);

    always_comb begin
        ld_ptr_lo = accept && (cmd_op == OP_PTR_LO);
        ld_ptr_hi = accept && (cmd_op == OP_PTR_HI);
        ld_lat_hi = accept && (cmd_op == OP_LAT_HI);
        ld_lat_lo = accept && (cmd_op == OP_WRITE);
        bump      = in_xfer && ph_last && inc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            inc_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept && cmd_op == OP_WRITE) begin
                        state  <= ST_PREP;
                        inc_q  <= cmd_inc;
                        seen_q <= int_req;
                    end
                end
                ST_PREP: begin
                    seen_q <= seen_q | int_req;
                    if (ph_last) state <= ST_XFER;
                end
                ST_XFER: begin
                    seen_q <= seen_q | int_req;
                    if (ph_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe = STROBE_IDLE;
        ad_out = '0;
        if (in_xfer) begin
            strobe.drive = 1'b1;
            strobe.ale   = (ph == '0);
            strobe.wr_n  = (ph != strobe_phase_wr());
            ad_out       = (ph == '0) ? ptr : latch;
        end
    end

    assign int_ack = in_xfer && ph_last && int_glob_off && int_src_en && (seen_q || int_req);

    p_ale_drive_r6: assert property (@(posedge clk) disable iff (rst)
        strobe.ale |-> strobe.drive);

    p_wr_after_ale_r7: assert property (@(posedge clk) disable iff (rst)
        !strobe.wr_n |-> $past(strobe.ale, 2));

    p_busy_end_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(strobe.drive));

    p_ack_tail_r11: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> !busy);

    p_quiet_bus_r12: assert property (@(posedge clk) disable iff (rst)
        !strobe.drive |-> (ad_out == '0));

endmodule

// File: rtl/tblwr_bus_seq.sv
module tblwr_bus_seq
    import tblwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_inc,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              int_req,
    input  logic              int_glob_off,
    input  logic              int_src_en,
    output logic [PH_W-1:0]   q_phase,
    output logic              busy,
    output logic              ale,
    output logic              oe_n,
    output logic              wr_n,
    output logic              ad_oe,
    output logic [WORD_W-1:0] ad_out,
    output logic [WORD_W-1:0] tbl_ptr,
    output logic              int_ack
);

    logic              ph_last;
    logic              ld_ptr_lo, ld_ptr_hi, ld_lat_hi, ld_lat_lo, bump;
    logic [WORD_W-1:0] latch;
    tw_strobe_s        strobe;

    tblwr_phase #(.NPH(NUM_PH), .PW(PH_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .ph      (q_phase),
        .ph_last (ph_last)
    );

    tblwr_regs #(.W(WORD_W), .BW(BYTE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ld_ptr_lo (ld_ptr_lo),
        .ld_ptr_hi (ld_ptr_hi),
        .ld_lat_hi (ld_lat_hi),
        .ld_lat_lo (ld_lat_lo),
        .bump      (bump),
        .din       (cmd_byte),
        .ptr       (tbl_ptr),
        .latch     (latch)
    );

    tblwr_ctrl #(.W(WORD_W), .BW(BYTE_W), .PW(PH_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ph           (q_phase),
        .ph_last      (ph_last),
        .cmd_valid    (cmd_valid),
        .cmd_op       (tw_op_e'(cmd_op)),
        .cmd_inc      (cmd_inc),
        .int_req      (int_req),
        .int_glob_off (int_glob_off),
        .int_src_en   (int_src_en),
        .ptr          (tbl_ptr),
        .latch        (latch),
        .ld_ptr_lo    (ld_ptr_lo),
        .ld_ptr_hi    (ld_ptr_hi),
        .ld_lat_hi    (ld_lat_hi),
        .ld_lat_lo    (ld_lat_lo),
        .bump         (bump),
        .busy         (busy),
        .strobe       (strobe),
        .ad_out       (ad_out),
        .int_ack      (int_ack)
    );

    assign ale   = strobe.ale;
    assign oe_n  = strobe.oe_n;
    assign wr_n  = strobe.wr_n;
    assign ad_oe = strobe.drive;

    p_ptr_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tbl_ptr));

    p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(q_phase) == PH_W'(NUM_PH - 1)));

endmodule

// File: tb/tblwr_bus_seq_tb_top.sv
module tblwr_bus_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_inc = 1'b0;
    logic [7:0]  cmd_byte = 8'd0;
    logic        int_req = 1'b0;
    logic        int_glob_off = 1'b0;
    logic        int_src_en = 1'b0;
    logic [1:0]  q_phase;
    logic        busy, ale, oe_n, wr_n, ad_oe, int_ack;
    logic [15:0] ad_out, tbl_ptr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tblwr_bus_seq dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_inc(cmd_inc), .cmd_byte(cmd_byte), .int_req(int_req),
        .int_glob_off(int_glob_off), .int_src_en(int_src_en),
        .q_phase(q_phase), .busy(busy), .ale(ale), .oe_n(oe_n), .wr_n(wr_n),
        .ad_oe(ad_oe), .ad_out(ad_out), .tbl_ptr(tbl_ptr), .int_ack(int_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: remaining busy clocks counted down
    int          m_ph = 0;
    int          m_cnt = 0;
    logic [15:0] m_ptr = '0;
    logic [15:0] m_lat = '0;
    bit          m_inc = 0;
    bit          m_seen = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_ptr = '0; m_lat = '0; m_inc = 0; m_seen = 0;
        end else begin
            if (m_cnt > 0) begin
                m_seen = m_seen | int_req;
                if (m_cnt == 1 && m_inc) m_ptr = m_ptr + 16'd1;
                m_cnt--;
            end else if (cmd_valid && m_ph == 3) begin
                case (cmd_op)
                    2'd0: m_ptr[7:0]  = cmd_byte;
                    2'd1: m_ptr[15:8] = cmd_byte;
                    2'd2: m_lat[15:8] = cmd_byte;
                    default: begin
                        m_lat[7:0] = cmd_byte;
                        m_cnt  = 8;
                        m_inc  = cmd_inc;
                        m_seen = int_req;
                    end
                endcase
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            logic [15:0] e_ad;
            e_ad = (m_cnt == 4) ? m_ptr : ((m_cnt >= 1 && m_cnt <= 3) ? m_lat : 16'd0);
            chk("R2 q_phase", 32'(q_phase), 32'(m_ph));
            chk("R5 busy", 32'(busy), 32'(m_cnt > 0));
            chk("R5 ad_oe", 32'(ad_oe), 32'(m_cnt >= 1 && m_cnt <= 4));
            chk("R6 ale", 32'(ale), 32'(m_cnt == 4));
            chk("R7 wr_n", 32'(wr_n), 32'(m_cnt != 2));
            chk("R7/R12 ad_out", 32'(ad_out), 32'(e_ad));
            chk("R8 oe_n", 32'(oe_n), 32'd1);
            chk("R9 tbl_ptr", 32'(tbl_ptr), 32'(m_ptr));
            chk("R11 int_ack", 32'(int_ack), 32'(m_cnt == 1 && int_glob_off && int_src_en && (m_seen || int_req)));
        end
    end

    task automatic issue(input logic [1:0] op, input logic [7:0] b, input logic inc);
        @(negedge clk);
        while (q_phase != 2'd3 || busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_inc = inc;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int acks;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 wr_n in reset", 32'(wr_n), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ptr", 32'(tbl_ptr), 32'd0);
        chk("R1 ale", 32'(ale), 32'd0);
        chk("R1 ad_oe", 32'(ad_oe), 32'd0);
        chk("R1 int_ack", 32'(int_ack), 32'd0);

        // basic write with increment
        issue(2'd0, 8'h34, 1'b0);
        issue(2'd1, 8'h12, 1'b0);
        issue(2'd2, 8'hAB, 1'b0);
        chk("R4 latch load leaves bus idle", 32'(busy), 32'd0);
        issue(2'd3, 8'hCD, 1'b1);
        wait_idle();
        chk("R9 increment after write", 32'(tbl_ptr), 32'h1235);

        // write without increment
        issue(2'd3, 8'h11, 1'b0);
        wait_idle();
        chk("R9 no increment", 32'(tbl_ptr), 32'h1235);

        // wrap
        issue(2'd0, 8'hFF, 1'b0);
        issue(2'd1, 8'hFF, 1'b0);
        issue(2'd3, 8'h22, 1'b1);
        wait_idle();
        chk("R9 wrap to zero", 32'(tbl_ptr), 32'h0000);

        // command while busy, including at the last Q4 of the write
        issue(2'd0, 8'h10, 1'b0);
        issue(2'd3, 8'h33, 1'b0);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_byte = 8'h77;
        while (busy) @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 busy command ignored", 32'(tbl_ptr), 32'h0010);

        // command outside Q4
        @(negedge clk);
        while (q_phase != 2'd1) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_byte = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R3 off-phase command ignored", 32'(tbl_ptr), 32'h0010);

        // interrupt acknowledge, request pulse in first machine cycle
        int_glob_off = 1'b1; int_src_en = 1'b1;
        issue(2'd3, 8'h44, 1'b1);
        int_req = 1'b1;
        @(negedge clk);
        int_req = 1'b0;
        acks = 0;
        while (busy) begin
            if (int_ack) acks++;
            @(negedge clk);
        end
        chk("R11 one ack per write", 32'(acks), 32'd1);

        // late request only in final Q4, same clock as increment
        issue(2'd3, 8'h45, 1'b1);
        acks = 0;
        while (busy) begin
            int_req = (q_phase == 2'd3 && ad_oe);
            #1;
            if (int_ack) acks++;
            @(negedge clk);
        end
        int_req = 1'b0;
        chk("R11 late request acked", 32'(acks), 32'd1);
        chk("R9 increment with ack", 32'(tbl_ptr), 32'h0012);

        // global mask clear: no ack
        int_glob_off = 1'b0;
        issue(2'd3, 8'h46, 1'b0);
        int_req = 1'b1;
        acks = 0;
        while (busy) begin
            if (int_ack) acks++;
            @(negedge clk);
        end
        int_req = 1'b0;
        chk("R11 no ack when unmasked", 32'(acks), 32'd0);

        // random stretch
        for (int i = 0; i < 600; i++) begin
            cmd_valid    = ($urandom % 3) == 0;
            cmd_op       = 2'($urandom);
            cmd_byte     = 8'($urandom);
            cmd_inc      = 1'($urandom);
            int_req      = ($urandom % 5) == 0;
            int_glob_off = 1'($urandom);
            int_src_en   = 1'($urandom);
            @(negedge clk);
        end
        cmd_valid = 1'b0; int_req = 1'b0;
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule